// File: doc/BRIEF.md
# Bidirectional Universal Shift Register with Shared Parallel Bus

This block is a register, eight bits wide by default, that on each rising clock edge does one of four things. It can keep its value. It can shift toward the high end. It can shift toward the low end. It can capture a word from a parallel bus. The parallel path is one bidirectional bus, used for capture during a load and for presenting the contents at other times. Here that bus is split into three ports: an input word, an output word and a drive-enable. An enclosing pad or bus model joins them.

Each end of the register has its own serial input. The two end bits also appear on dedicated serial outputs, and these are always active. Chaining several registers through these pins gives a wider shifter. A synchronous active-low clear overrides the mode select. Two active-low enables gate the bus drive. The bus drive is also withheld while the mode selects a load, so that an outside source can drive the bus.

Top module: `ushift_reg`

## Requirements
- R1: When `rstN` is low at a rising edge, every register bit becomes 0, whatever the value of `modeSel`.
- R2: With `modeSel` = 2'b00 (hold), the register keeps its value across the edge.
- R3: With `modeSel` = 2'b01 (shift up), `serInLo` enters bit 0 and each bit n moves to bit n+1. The old top bit is dropped.
- R4: With `modeSel` = 2'b10 (shift down), `serInHi` enters bit WIDTH-1 and each bit n moves to bit n-1. The old bit 0 is dropped.
- R5: With `modeSel` = 2'b11 (load), the register captures `busIn` at the edge.
- R6: `busOutEn` is 1 only when `oeAN` and `oeBN` are both 0 and `modeSel` is not 2'b11. The relation is combinational.
- R7: `busOut` always equals the register contents, whether or not the drive is enabled.
- R8: `serOutLo` always equals bit 0 and `serOutHi` always equals bit WIDTH-1.
- R9: Clear, shift, load and hold take place normally while `busOutEn` is 0.
- R10: Two instances can form a 2*WIDTH-bit shifter in both directions. For this, the low instance's `serOutHi` feeds the high instance's `serInLo`, and the high instance's `serOutLo` feeds the low instance's `serInHi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous clear, active low, overrides the mode |
| modeSel | input | 2 | Operation: 00 hold, 01 shift up, 10 shift down, 11 load |
| serInLo | input | 1 | Serial data entering bit 0 on a shift up |
| serInHi | input | 1 | Serial data entering the top bit on a shift down |
| oeAN | input | 1 | Bus drive enable A, active low |
| oeBN | input | 1 | Bus drive enable B, active low |
| busIn | input | WIDTH | Parallel word sampled during a load |
| busOut | output | WIDTH | Current register contents |
| busOutEn | output | 1 | Bus drive enable for the pad |
| serOutLo | output | 1 | Bit 0, always driven |
| serOutHi | output | 1 | Top bit, always driven |

## Verification
All state is visible on `busOut` one cycle after each edge. So a wrong next-state choice, such as a swapped shift direction, a lost serial input or an ignored clear, shows up on the very next sample. A fault in the drive-enable decode shows up combinationally, in the same cycle as the inputs that cause it. The bench cascades two instances, so that faults on the end bits and serial paths travel into the neighbouring register. There they are caught one cycle later against a 16-bit reference model.

// File: rtl/ushift_pkg.sv
package ushift_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } shiftMode_e;

  typedef struct packed {
    logic clear;
    logic load;
    logic shiftUp;
    logic shiftDown;
    logic drive;
  } ctrlStrobe_t;
endpackage

// File: rtl/ushift_ctrl.sv
module ushift_ctrl
  import ushift_pkg::*;
(
  input  logic        rstN,
  input  logic [1:0]  modeSel,
  input  logic        oeAN,
  input  logic        oeBN,
  output ctrlStrobe_t strobe
);
  shiftMode_e mode;
  assign mode = shiftMode_e'(modeSel);

  always_comb begin
    strobe = '0;
    // Clear wins over every mode.
    if (!rstN) begin
      strobe.clear = 1'b1;
    end else begin
      unique case (mode)
        MODE_LOAD: strobe.load      = 1'b1;
        MODE_UP:   strobe.shiftUp   = 1'b1;
        MODE_DOWN: strobe.shiftDown = 1'b1;
        default:   ;
      endcase
    end
    // The drive depends on the mode only, not on the clear.
    strobe.drive = !oeAN && !oeBN && (mode != MODE_LOAD);
  end
endmodule

// File: rtl/ushift_dp.sv
module ushift_dp
  import ushift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  ctrlStrobe_t      strobe,
  input  logic             serInLo,
  input  logic             serInHi,
  input  logic [WIDTH-1:0] busIn,
  output logic [WIDTH-1:0] q
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] upSrc;
  logic [WIDTH-1:0] downSrc;
  logic [WIDTH-1:0] nextQ;

  assign upSrc   = {q[TOP-1:0], serInLo};
  assign downSrc = {serInHi, q[TOP:1]};

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      if (strobe.clear)          nextQ[i] = 1'b0;
      else if (strobe.load)      nextQ[i] = busIn[i];
      else if (strobe.shiftUp)   nextQ[i] = upSrc[i];
      else if (strobe.shiftDown) nextQ[i] = downSrc[i];
      else                       nextQ[i] = q[i];
    end
  end

  always_ff @(posedge clk) begin
    q <= nextQ;
  end
endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
  import ushift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             serInLo,
  input  logic             serInHi,
  input  logic             oeAN,
  input  logic             oeBN,
  input  logic [WIDTH-1:0] busIn,
  output logic [WIDTH-1:0] busOut,
  output logic             busOutEn,
  output logic             serOutLo,
  output logic             serOutHi
);
  ctrlStrobe_t strobe;
  logic [WIDTH-1:0] regQ;

  ushift_ctrl u_ctrl (
    .rstN(rstN), .modeSel(modeSel), .oeAN(oeAN), .oeBN(oeBN), .strobe(strobe)
  );

  ushift_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .strobe(strobe), .serInLo(serInLo), .serInHi(serInHi),
    .busIn(busIn), .q(regQ)
  );

  assign busOut   = regQ;
  assign busOutEn = strobe.drive;
  assign serOutLo = regQ[0];
  assign serOutHi = regQ[WIDTH-1];
endmodule

// File: rtl/ushift_reg_chk.sv
module ushift_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       modeSel,
  input logic             serInLo,
  input logic             serInHi,
  input logic             oeAN,
  input logic             oeBN,
  input logic [WIDTH-1:0] busIn,
  input logic [WIDTH-1:0] busOut,
  input logic             busOutEn,
  input logic             serOutLo,
  input logic             serOutHi
);
  // R1: the clear is itself the checked behaviour, so no disable on it.
  p_clear_r1: assert property (@(posedge clk) !rstN |=> busOut == '0);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && modeSel == 2'b00) |=> $stable(busOut));

  p_shift_up_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && modeSel == 2'b01) |=> busOut == {$past(busOut[WIDTH-2:0]), $past(serInLo)});

  p_shift_down_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && modeSel == 2'b10) |=> busOut == {$past(serInHi), $past(busOut[WIDTH-1:1])});

  p_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && modeSel == 2'b11) |=> busOut == $past(busIn));

  p_off_in_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b11) |-> !busOutEn);

  p_off_by_enable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (oeAN || oeBN) |-> !busOutEn);

  p_ends_r8: assert property (@(posedge clk) disable iff (!rstN)
    (serOutLo == busOut[0]) && (serOutHi == busOut[WIDTH-1]));
endmodule

bind ushift_reg ushift_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .serInLo(serInLo),
  .serInHi(serInHi), .oeAN(oeAN), .oeBN(oeBN), .busIn(busIn),
  .busOut(busOut), .busOutEn(busOutEn), .serOutLo(serOutLo),
  .serOutHi(serOutHi)
);

// File: tb/ushift_reg_test.sv
module ushift_reg_test;
  localparam int W = 8;
  localparam int CW = 2 * W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN = 1'b0;
  logic [1:0]    modeSel = 2'b00;
  logic          chainInLo = 1'b0, chainInHi = 1'b0;
  logic          oeAN = 1'b1, oeBN = 1'b1;
  logic [CW-1:0] busIn = '0;

  logic [W-1:0] outLo, outHi;
  logic enLo, enHi, soLoLo, soLoHi, soHiLo, soHiHi;

  // R10: chained pair, low instance holds bits 7..0.
  ushift_reg #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .serInLo(chainInLo),
    .serInHi(soHiLo), .oeAN(oeAN), .oeBN(oeBN), .busIn(busIn[W-1:0]),
    .busOut(outLo), .busOutEn(enLo), .serOutLo(soLoLo), .serOutHi(soLoHi));
  ushift_reg #(.WIDTH(W)) uutHi (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .serInLo(soLoHi),
    .serInHi(chainInHi), .oeAN(oeAN), .oeBN(oeBN), .busIn(busIn[CW-1:W]),
    .busOut(outHi), .busOutEn(enHi), .serOutLo(soHiLo), .serOutHi(soHiHi));

  int checks = 0, fails = 0;
  logic [CW-1:0] model = '0;
  bit done = 0;

  function automatic logic [CW-1:0] nextModel(logic [CW-1:0] cur, logic r,
      logic [1:0] m, logic sl, logic sh, logic [CW-1:0] b);
    if (!r) return '0;
    case (m)
      2'b01:   return {cur[CW-2:0], sl};
      2'b10:   return {sh, cur[CW-1:1]};
      2'b11:   return b;
      default: return cur;
    endcase
  endfunction

  function automatic logic expEn(logic a, logic b, logic [1:0] m);
    return (a == 1'b0) && (b == 1'b0) && (m != 2'b11);
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string modeTag(logic r, logic [1:0] m);
    if (!r) return "R1 clear";
    case (m)
      2'b00:   return "R2 hold";
      2'b01:   return "R3/R10 shift up";
      2'b10:   return "R4/R10 shift down";
      default: return "R5 load";
    endcase
  endfunction

  // Apply one cycle: drive at negedge, check enable, clock, check state.
  task automatic step(input logic r, input logic [1:0] m, input logic sl,
      input logic sh, input logic a, input logic b, input logic [CW-1:0] d);
    logic en;
    rstN = r; modeSel = m; chainInLo = sl; chainInHi = sh;
    oeAN = a; oeBN = b; busIn = d;
    #1;
    en = expEn(a, b, m);
    check(enLo == en && enHi == en, "R6 drive enable", {enHi, enLo}, {en, en});
    model = nextModel(model, r, m, sl, sh, d);
    @(negedge clk);
    check({outHi, outLo} == model,
          (a || b || m == 2'b11) ? {modeTag(r, m), " R7/R9 drive off"} : modeTag(r, m),
          {outHi, outLo}, model);
    check(soLoLo == model[0] && soLoHi == model[W-1] &&
          soHiLo == model[W] && soHiHi == model[CW-1], "R8 serial ends",
          {soHiHi, soHiLo, soLoHi, soLoLo},
          {model[CW-1], model[W], model[W-1], model[0]});
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    // R1: reset state, clear while load is selected.
    step(1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 16'hFFFF);
    check({outHi, outLo} == 16'h0000, "R1 reset state", {outHi, outLo}, 0);
    step(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'hA5C3);   // R5 load
    step(1'b0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000);   // R1 priority over shift
    // R10: walk a one across the full 16-bit chain and back.
    step(1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0);
    for (int k = 0; k < CW - 1; k++) step(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
    for (int k = 0; k < CW - 1; k++) step(1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
    // R9: load and hold with both enables off.
    step(1'b1, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 16'h3C69);
    step(1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 16'hFFFF);
    // Random mix.
    for (int k = 0; k < 400; k++) begin
      step(($urandom % 10) != 0, 2'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 16'($urandom));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule